// File: doc/BRIEF.md
# Debug Halt Freeze Controller

This block holds one 32-bit debug configuration word and turns it into the control signals a chip needs while a debugger has stopped the processor core. Whenever the core-halted flag is high, each enabled field freezes its peripheral. Timers lose their counter clock, and the larger timers also have their outputs forced into the disabled state. The two watchdogs lose their counter clocks. Two CAN receivers hold their receive registers. Two SMBus timeout counters stop counting. When the flag drops, everything is released.

The same word selects how the trace pins are assigned. It also chooses whether clocks stay alive in the three low-power modes (sleep, stop and standby), so that a debugger can stay attached through them. With the standby keep-alive set, entering standby produces a one-cycle system-reset request, so leaving standby still looks like a reset.

The word is cleared only by power-on reset and keeps its value through a system reset. Software writes it through a simple full-width port. Bits that have no function always read as zero.

Top module: `dbg_freeze_ctrl`

## Requirements
- R1: While `por_n` is low on a clock edge, the register becomes 0x00000000, and every freeze output is 0 from the next edge on.
- R2: A system reset (`sys_rst_n` low, `por_n` high) leaves the register unchanged and holds every freeze output at 0 while it is asserted.
- R3: A write is accepted only when `acc_full` is 1. `rd_data` shows the register only when `rd_en` and `acc_full` are both 1, and shows 0 otherwise.
- R4: Bits 31, 24:22, 13, 10 and 4:3 always read as 0, whatever is written (writable mask 0x7E3FDBE7).
- R5: Timer freeze `tim_stop[1:0]`, `[5:2]` and `[11:6]` come from bits 12:11, 20:17 and 30:25 in that order. Each is set in the cycle after `core_halted` is sampled high, and clears in the cycle after it is sampled low.
- R6: `tim_out_dis[9:0]` follows the same halt gating for bits 20:17 (indices 3:0) and 30:25 (indices 9:4).
- R7: `wwdg_stop` comes from bit 9 and `iwdg_stop` comes from bit 8, both gated by halt.
- R8: `can_rx_hold[0]` and `can_rx_hold[1]` come from bits 14 and 21. `smb_to_hold[0]` and `smb_to_hold[1]` come from bits 15 and 16. All four are gated by halt.
- R9: The trace enable is bit 5 and the trace mode is bits 7:6. With the enable at 0, `trace_pins_en`, `trace_sync` and `trace_width` are all 0. With the enable at 1, mode 0 gives asynchronous trace (`trace_sync` 0, width 0), and modes 1, 2 and 3 give synchronous trace with widths 1, 2 and 4.
- R10: `lp_mode` encodes run=0, sleep=1, stop=2, standby=3. In run, all four clock controls (`core_clk_en`, `bus_clk_en`, `dom_pwr_on`, and `clk_src_rc`=0) take their normal values. In sleep, `core_clk_en`=1, `bus_clk_en` equals bit 0, and `clk_src_rc`=0.
- R11: In stop, `core_clk_en`, `bus_clk_en` and `clk_src_rc` all equal bit 1, and `dom_pwr_on`=1.
- R12: In standby, all four clock controls equal bit 2. `sb_rst_req` is high for exactly the first cycle that `lp_mode` shows standby, and only when bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| sys_rst_n | input | 1 | System reset, active low, synchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| acc_full | input | 1 | Access is full 32-bit width |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data |
| core_halted | input | 1 | Core stopped by debugger |
| lp_mode | input | 2 | Low-power state |
| tim_stop | output | 12 | Timer counter clock stop |
| tim_out_dis | output | 10 | Timer output disable |
| wwdg_stop | output | 1 | Window watchdog clock stop |
| iwdg_stop | output | 1 | Independent watchdog clock stop |
| can_rx_hold | output | 2 | CAN receive register freeze |
| smb_to_hold | output | 2 | SMBus timeout freeze |
| trace_pins_en | output | 1 | Trace pins assigned |
| trace_sync | output | 1 | Synchronous trace selected |
| trace_width | output | 3 | Synchronous trace data lines |
| core_clk_en | output | 1 | Core clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| clk_src_rc | output | 1 | Clocks sourced from internal RC oscillator |
| dom_pwr_on | output | 1 | Digital domain powered |
| sb_rst_req | output | 1 | System reset request on standby entry |

## Verification
The bench walks a single one through every bit of the word, with the core halted and with it running. A design with a wrong bit mapping or a writable reserved bit therefore shows up as a stray freeze output or a non-zero readback. It checks the freeze output just before and just after the clock edge that follows a halt change, which catches unregistered, glitch-prone freeze logic. It writes a non-zero word and then asserts system reset; a design that clears the word there would lose the debugger's setup. It also sweeps every low-power mode against every keep-alive pattern, and checks that the standby reset request is a single pulse and does not repeat while standby continues.

// File: rtl/dbgf_pkg.sv
package dbgf_pkg;
  localparam int REG_W      = 32;
  localparam int N_TIM_LO   = 2;
  localparam int N_TIM_MID  = 4;
  localparam int N_TIM_HI   = 6;
  localparam int N_TIM      = N_TIM_LO + N_TIM_MID + N_TIM_HI;
  localparam int N_TIM_ADV  = N_TIM_MID + N_TIM_HI;
  localparam int TW_W       = 3;
  localparam logic [REG_W-1:0] WR_MASK = 32'h7E3F_DBE7;

  typedef enum logic [1:0] {
    LP_RUN     = 2'd0,
    LP_SLEEP   = 2'd1,
    LP_STOP    = 2'd2,
    LP_STANDBY = 2'd3
  } lp_mode_e;

  typedef struct packed {
    logic core_en;
    logic bus_en;
    logic rc_src;
    logic pwr_on;
  } clk_ctl_t;

  function automatic clk_ctl_t lp_clocks(lp_mode_e m, logic [2:0] keep);
    clk_ctl_t c;
    case (m)
      LP_SLEEP:   c = '{core_en: 1'b1, bus_en: keep[0], rc_src: 1'b0, pwr_on: 1'b1};
      LP_STOP:    c = '{core_en: keep[1], bus_en: keep[1], rc_src: keep[1], pwr_on: 1'b1};
      LP_STANDBY: c = '{core_en: keep[2], bus_en: keep[2], rc_src: keep[2], pwr_on: keep[2]};
      default:    c = '{core_en: 1'b1, bus_en: 1'b1, rc_src: 1'b0, pwr_on: 1'b1};
    endcase
    return c;
  endfunction

  function automatic logic [TW_W-1:0] trace_lines(logic en, logic [1:0] mode);
    if (!en || mode == 2'd0) return '0;
    return TW_W'(3'd1 << (mode - 2'd1));
  endfunction
endpackage

// File: rtl/dbgf_cfg_reg.sv
module dbgf_cfg_reg
  import dbgf_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!por_n)  q <= '0;
    else if (we) q <= wdata & WR_MASK;
  end
endmodule

// File: rtl/dbgf_freeze.sv
module dbgf_freeze
  import dbgf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 halted,
  input  logic [N_TIM-1:0]     tim_en,
  input  logic [1:0]           wdg_en,
  input  logic [1:0]           can_en,
  input  logic [1:0]           smb_en,
  output logic [N_TIM-1:0]     tim_stop,
  output logic [N_TIM_ADV-1:0] tim_out_dis,
  output logic [1:0]           wdg_stop,
  output logic [1:0]           can_hold,
  output logic [1:0]           smb_hold
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tim_stop <= '0;
      wdg_stop <= '0;
      can_hold <= '0;
      smb_hold <= '0;
    end else begin
      tim_stop <= halted ? tim_en : '0;
      wdg_stop <= halted ? wdg_en : '0;
      can_hold <= halted ? can_en : '0;
      smb_hold <= halted ? smb_en : '0;
    end
  end

  // advanced timers are the upper entries of the timer vector
  for (genvar i = 0; i < N_TIM_ADV; i++) begin : g_odis
    assign tim_out_dis[i] = tim_stop[N_TIM_LO + i];
  end
endmodule

// File: rtl/dbgf_lp_ctl.sv
module dbgf_lp_ctl
  import dbgf_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic [1:0] lp_mode,
  input  logic [2:0] keep,
  output logic       core_clk_en,
  output logic       bus_clk_en,
  output logic       clk_src_rc,
  output logic       dom_pwr_on,
  output logic       sb_rst_req
);
  lp_mode_e mode_now, mode_prev;
  clk_ctl_t ctl;

  assign mode_now = lp_mode_e'(lp_mode);
  assign ctl      = lp_clocks(mode_now, keep);

  assign core_clk_en = ctl.core_en;
  assign bus_clk_en  = ctl.bus_en;
  assign clk_src_rc  = ctl.rc_src;
  assign dom_pwr_on  = ctl.pwr_on;

  // previous mode is kept across system reset so the pulse cannot repeat
  always_ff @(posedge clk) begin
    if (!por_n) mode_prev <= LP_RUN;
    else        mode_prev <= mode_now;
  end

  assign sb_rst_req = keep[2] && (mode_now == LP_STANDBY) && (mode_prev != LP_STANDBY);
endmodule

// File: rtl/dbg_freeze_ctrl.sv
module dbg_freeze_ctrl
  import dbgf_pkg::*;
(
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 sys_rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic                 acc_full,
  input  logic [REG_W-1:0]     wr_data,
  output logic [REG_W-1:0]     rd_data,
  input  logic                 core_halted,
  input  logic [1:0]           lp_mode,
  output logic [N_TIM-1:0]     tim_stop,
  output logic [N_TIM_ADV-1:0] tim_out_dis,
  output logic                 wwdg_stop,
  output logic                 iwdg_stop,
  output logic [1:0]           can_rx_hold,
  output logic [1:0]           smb_to_hold,
  output logic                 trace_pins_en,
  output logic                 trace_sync,
  output logic [TW_W-1:0]      trace_width,
  output logic                 core_clk_en,
  output logic                 bus_clk_en,
  output logic                 clk_src_rc,
  output logic                 dom_pwr_on,
  output logic                 sb_rst_req
);
  logic [REG_W-1:0] cfg_q;
  logic             cfg_we;
  logic             frz_rst_n;
  logic [N_TIM-1:0] tim_en;
  logic [1:0]       wdg_stop;

  assign cfg_we    = wr_en && acc_full;
  assign frz_rst_n = por_n && sys_rst_n;
  assign rd_data   = (rd_en && acc_full) ? cfg_q : '0;

  dbgf_cfg_reg u_cfg (
    .clk  (clk),
    .por_n(por_n),
    .we   (cfg_we),
    .wdata(wr_data),
    .q    (cfg_q)
  );

  assign tim_en = {cfg_q[30:25], cfg_q[20:17], cfg_q[12:11]};

  dbgf_freeze u_frz (
    .clk        (clk),
    .rst_n      (frz_rst_n),
    .halted     (core_halted),
    .tim_en     (tim_en),
    .wdg_en     (cfg_q[9:8]),
    .can_en     ({cfg_q[21], cfg_q[14]}),
    .smb_en     (cfg_q[16:15]),
    .tim_stop   (tim_stop),
    .tim_out_dis(tim_out_dis),
    .wdg_stop   (wdg_stop),
    .can_hold   (can_rx_hold),
    .smb_hold   (smb_to_hold)
  );
  assign wwdg_stop = wdg_stop[1];
  assign iwdg_stop = wdg_stop[0];

  assign trace_pins_en = cfg_q[5];
  assign trace_sync    = cfg_q[5] && (cfg_q[7:6] != 2'd0);
  assign trace_width   = trace_lines(cfg_q[5], cfg_q[7:6]);

  dbgf_lp_ctl u_lp (
    .clk        (clk),
    .por_n      (por_n),
    .lp_mode    (lp_mode),
    .keep       (cfg_q[2:0]),
    .core_clk_en(core_clk_en),
    .bus_clk_en (bus_clk_en),
    .clk_src_rc (clk_src_rc),
    .dom_pwr_on (dom_pwr_on),
    .sb_rst_req (sb_rst_req)
  );
endmodule

// File: rtl/dbg_freeze_chk.sv
module dbg_freeze_chk
  import dbgf_pkg::*;
(
  input logic                 clk,
  input logic                 por_n,
  input logic                 sys_rst_n,
  input logic                 core_halted,
  input logic [1:0]           lp_mode,
  input logic [REG_W-1:0]     cfg_q,
  input logic                 cfg_we,
  input logic [N_TIM-1:0]     tim_stop,
  input logic [N_TIM_ADV-1:0] tim_out_dis,
  input logic                 wwdg_stop,
  input logic                 iwdg_stop,
  input logic                 trace_pins_en,
  input logic                 core_clk_en,
  input logic                 sb_rst_req
);
  a_r2_sysrst_keeps_cfg: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst_n && !cfg_we) |=> $stable(cfg_q));

  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_q & ~WR_MASK) == '0);

  a_r5_release_after_run: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    !core_halted |=> (tim_stop == '0));

  a_r5_freeze_follows_cfg: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    core_halted |=> (tim_stop == $past({cfg_q[30:25], cfg_q[20:17], cfg_q[12:11]})));

  a_r6_outdis_implies_stop: assert property (@(posedge clk) disable iff (!por_n)
    (tim_out_dis & ~tim_stop[N_TIM-1:N_TIM_LO]) == '0);

  a_r7_wdg_only_halted: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    !core_halted |=> (!wwdg_stop && !iwdg_stop));

  a_r9_trace_off: assert property (@(posedge clk) disable iff (!por_n)
    !cfg_q[5] |-> !trace_pins_en);

  a_r10_sleep_core_on: assert property (@(posedge clk) disable iff (!por_n)
    (lp_mode == 2'd1) |-> core_clk_en);

  a_r12_sb_pulse_single: assert property (@(posedge clk) disable iff (!por_n)
    sb_rst_req |=> !sb_rst_req);
endmodule

bind dbg_freeze_ctrl dbg_freeze_chk chk_i (.*);

// File: tb/dbg_freeze_ctrl_tb.sv
module dbg_freeze_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, sys_rst_n = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, acc_full = 1'b1;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        core_halted = 1'b0;
  logic [1:0]  lp_mode = 2'd0;
  logic [11:0] tim_stop;
  logic [9:0]  tim_out_dis;
  logic        wwdg_stop, iwdg_stop;
  logic [1:0]  can_rx_hold, smb_to_hold;
  logic        trace_pins_en, trace_sync;
  logic [2:0]  trace_width;
  logic        core_clk_en, bus_clk_en, clk_src_rc, dom_pwr_on, sb_rst_req;

  int n_tests = 0, n_fail = 0;
  logic [31:0] model = '0;
  localparam logic [31:0] MASK = 32'h7E3F_DBE7;

  always #5 clk = ~clk;

  dbg_freeze_ctrl dut_i (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d, logic full);
    @(negedge clk);
    wr_en = 1'b1; acc_full = full; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; acc_full = 1'b1;
    if (full) model = d & MASK;
  endtask

  task automatic rd_chk(string req, logic full);
    @(negedge clk);
    rd_en = 1'b1; acc_full = full;
    #2 chk(req, rd_data, full ? model : 32'h0);
    rd_en = 1'b0; acc_full = 1'b1;
  endtask

  // expected freeze group, built from the field positions in the requirements
  function automatic logic [27:0] exp_frz(logic h, logic [31:0] m);
    logic [11:0] t;
    t = {m[30:25], m[20:17], m[12:11]};
    if (!h) return '0;
    return {t, t[11:2], m[9], m[8], m[21], m[14], m[16], m[15]};
  endfunction

  function automatic logic [27:0] act_frz();
    return {tim_stop, tim_out_dis, wwdg_stop, iwdg_stop, can_rx_hold, smb_to_hold};
  endfunction

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R1 rd after por", rd_data, 32'h0);
        por_n = 1'b1;
        rd_chk("R1 reset value", 1'b1);
        chk("R1 freeze idle", act_frz(), 28'h0);

        // R4/R5-R8: walking one through every bit, halted and running
        for (int b = 0; b < 32; b++) begin
          for (int h = 0; h < 2; h++) begin
            core_halted = h[0];
            wr(32'h1 << b, 1'b1);
            @(negedge clk);
            chk($sformatf("R4 readback bit %0d", b), {rd_en ? rd_data : dut_i.rd_data}, 32'h0);
            rd_chk($sformatf("R4 masked bit %0d", b), 1'b1);
            chk($sformatf("R5 R6 R7 R8 freeze bit %0d h %0d", b, h), act_frz(), exp_frz(h[0], model));
          end
        end

        // R5: halt edge timing
        core_halted = 1'b0;
        wr(32'h7E3F_DB00, 1'b1);
        @(negedge clk);
        core_halted = 1'b1;
        #2 chk("R5 not before edge", act_frz(), 28'h0);
        @(negedge clk);
        chk("R5 set after edge", act_frz(), exp_frz(1'b1, model));
        core_halted = 1'b0;
        #2 chk("R5 held before edge", act_frz(), exp_frz(1'b1, model));
        @(negedge clk);
        chk("R5 released", act_frz(), 28'h0);

        // R3: partial-width write ignored, partial read returns zero
        wr(32'h0000_1800, 1'b1);
        wr(32'h7E00_0000, 1'b0);
        rd_chk("R3 partial write ignored", 1'b1);
        rd_chk("R3 partial read zero", 1'b0);
        @(negedge clk);
        chk("R3 idle read zero", rd_data, 32'h0);

        // R2: system reset keeps word, clears freeze
        wr(32'hFFFF_FFFF, 1'b1);
        core_halted = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R2 frozen before sysrst", act_frz(), exp_frz(1'b1, model));
        sys_rst_n = 1'b0;
        @(negedge clk);
        chk("R2 freeze cleared", act_frz(), 28'h0);
        @(negedge clk);
        sys_rst_n = 1'b1;
        rd_chk("R2 word kept", 1'b1);
        core_halted = 1'b0;

        // R9: all trace settings
        for (int t = 0; t < 8; t++) begin
          logic [2:0] w;
          wr(32'(t) << 5, 1'b1);
          w = (t[0] && t[2:1] != 0) ? (3'd1 << (t[2:1] - 1)) : 3'd0;
          chk($sformatf("R9 trace %0d", t), {trace_pins_en, trace_sync, trace_width},
              {t[0], t[0] && (t[2:1] != 0), w});
        end

        // R10-R12: all modes against all keep-alive patterns
        for (int k = 0; k < 8; k++) begin
          wr(32'(k), 1'b1);
          for (int m = 0; m < 4; m++) begin
            logic [3:0] e;
            @(negedge clk);
            lp_mode = m[1:0];
            case (m)
              1: e = {1'b1, k[0], 1'b0, 1'b1};
              2: e = {k[1], k[1], k[1], 1'b1};
              3: e = {k[2], k[2], k[2], k[2]};
              default: e = 4'b1101;
            endcase
            #2;
            chk($sformatf("R10 R11 R12 clocks m%0d k%0d", m, k),
                {core_clk_en, bus_clk_en, clk_src_rc, dom_pwr_on}, e);
            chk($sformatf("R12 sb pulse m%0d k%0d", m, k), sb_rst_req, (m == 3) && k[2]);
          end
          @(negedge clk);
          chk($sformatf("R12 single pulse k%0d", k), sb_rst_req, 1'b0);
          lp_mode = 2'd0;
        end

        // R1: power-on reset clears the word
        wr(32'h7E3F_DBE7, 1'b1);
        core_halted = 1'b1;
        @(negedge clk);
        por_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        por_n = 1'b1;
        model = '0;
        rd_chk("R1 por clears", 1'b1);
        chk("R1 freeze after por", act_frz(), 28'h0);
      end
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule